// File: doc/BRIEF.md
# Receive frame length filter

This block sits behind a receive MAC and judges every incoming frame by its byte length and its CRC result. Bytes arrive one per cycle with a valid qualifier and first-byte and last-byte markers. A CRC-good flag is sampled together with the last byte. The block counts the bytes of the frame, sorts the frame into one of three classes (runt, normal or oversize), and decides whether to keep it. It signals the decision with a one-cycle accept or drop pulse.

The byte stream is passed on one cycle late and otherwise unchanged. A discard marker rides on the last byte of every rejected frame, so a downstream buffer can release the space the frame took. Two configuration inputs control the length checks. One lets runts with a good CRC through. The other lets oversize frames through as long as they fit under a programmable buffer limit. When both inputs are low, only normal-length frames with a good CRC are kept. Three saturating counters record accepted frames, rejected runts and rejected oversize frames.

Top module: `rx_len_filter`

## Requirements
- R1: The frame length is the number of valid beats from the first-byte beat through the last-byte beat, inclusive. A frame of 64 to 1522 bytes is accepted when the CRC flag is 1 on its last beat, and dropped when that flag is 0.
- R2: A frame of fewer than 64 bytes is dropped whenever `cfg_short_en` is 0, whatever its CRC flag.
- R3: With `cfg_short_en` at 1, a frame of fewer than 64 bytes is accepted if its CRC flag is 1, and dropped if it is 0.
- R4: A frame of more than 1522 bytes is dropped whenever `cfg_long_en` is 0.
- R5: With `cfg_long_en` at 1, a frame of more than 1522 bytes is accepted only if its length is at most `cfg_buf_limit` and its CRC flag is 1. Otherwise it is dropped.
- R6: Each frame produces exactly one pulse, on either `acc_pulse` or `drop_pulse`. The pulse lasts one cycle and appears in the cycle after the last-byte beat. Cycles with `in_valid` at 0 do not count toward the length and do not change the result.
- R7: Every valid beat reappears on the output stream one cycle later with the same data and markers. `out_discard` is 1 on the last byte of a dropped frame and 0 on every other output beat.
- R8: `cnt_accept` counts accepted frames. `cnt_runt_drop` counts dropped frames under 64 bytes, and `cnt_long_drop` counts dropped frames over 1522 bytes. A counter's new value is visible in the same cycle as the decision pulse. Each counter holds at 65535 instead of wrapping.
- R9: The byte counter holds at its largest value (16383 by default). A frame longer than that is therefore still classed as oversize and never as a runt.
- R10: While reset is asserted and right after it, the pulses, the output stream and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat carries a byte |
| in_sof | input | 1 | First byte of a frame (after the SFD) |
| in_eof | input | 1 | Last byte of a frame (final FCS byte) |
| in_data | input | 8 | Frame byte |
| in_crc_ok | input | 1 | CRC result, sampled with the last byte |
| cfg_short_en | input | 1 | Allow runts that have a good CRC |
| cfg_long_en | input | 1 | Allow oversize frames up to the buffer limit |
| cfg_buf_limit | input | LEN_W | Largest oversize length admitted |
| out_valid | output | 1 | Forwarded beat valid |
| out_sof | output | 1 | Forwarded first-byte marker |
| out_eof | output | 1 | Forwarded last-byte marker |
| out_data | output | 8 | Forwarded byte |
| out_discard | output | 1 | Last byte of a rejected frame |
| acc_pulse | output | 1 | Frame accepted |
| drop_pulse | output | 1 | Frame dropped |
| cnt_accept | output | CNT_W | Accepted-frame count |
| cnt_runt_drop | output | CNT_W | Dropped-runt count |
| cnt_long_drop | output | CNT_W | Dropped-oversize count |

## Verification
The situations hardest to reach from the ports are the two saturation cases. The byte counter only saturates on a frame longer than 16383 bytes. The bench sends one such frame with runts enabled, so a counter that wrapped would accept it as a short frame, while a saturating counter drops it as oversize. The frame counter only saturates after 65535 accepts. To reach that quickly, the bench sends 65540 back-to-back one-byte frames, each with its first-byte and last-byte markers on the same beat. Gapped frames and the oversize limit boundary, tested one byte on each side of the limit, are covered in the vector table.

// File: rtl/rxlf_pkg.sv
package rxlf_pkg;
  typedef enum logic [1:0] {
    LCLS_NORMAL = 2'd0,
    LCLS_RUNT   = 2'd1,
    LCLS_LONG   = 2'd2
  } len_class_e;

  localparam int NUM_STAT = 3;
  localparam int STAT_ACC  = 0;
  localparam int STAT_RUNT = 1;
  localparam int STAT_LONG = 2;
endpackage

// File: rtl/rxlf_len_counter.sv
module rxlf_len_counter #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_valid,
  input  logic             beat_first,
  output logic [LEN_W-1:0] len_now
);
  localparam logic [LEN_W-1:0] LEN_TOP = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (beat_first)
      cnt_d = LEN_ONE;
    else if (cnt_q != LEN_TOP)
      cnt_d = cnt_q + LEN_ONE;
  end

  assign len_now = cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (beat_valid)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rxlf_classify.sv
module rxlf_classify
  import rxlf_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1522
) (
  input  logic [LEN_W-1:0] len,
  input  logic             crc_ok,
  input  logic             short_en,
  input  logic             long_en,
  input  logic [LEN_W-1:0] buf_limit,
  output logic             keep,
  output len_class_e       len_cls
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  always_comb begin
    if (len < MIN_L) begin
      len_cls = LCLS_RUNT;
      keep    = short_en && crc_ok;
    end else if (len > MAX_L) begin
      len_cls = LCLS_LONG;
      keep    = long_en && crc_ok && (len <= buf_limit);
    end else begin
      len_cls = LCLS_NORMAL;
      keep    = crc_ok;
    end
  end
endmodule

// File: rtl/rxlf_sat_counter.sv
module rxlf_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != TOP);
    cnt_d  = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rx_len_filter.sv
module rx_len_filter
  import rxlf_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1522,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic             in_crc_ok,
  input  logic             cfg_short_en,
  input  logic             cfg_long_en,
  input  logic [LEN_W-1:0] cfg_buf_limit,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [7:0]       out_data,
  output logic             out_discard,
  output logic             acc_pulse,
  output logic             drop_pulse,
  output logic [CNT_W-1:0] cnt_accept,
  output logic [CNT_W-1:0] cnt_runt_drop,
  output logic [CNT_W-1:0] cnt_long_drop
);
  logic [LEN_W-1:0] len_now;
  logic             keep;
  len_class_e       len_cls;
  logic             frame_end;
  logic [NUM_STAT-1:0] stat_inc;
  logic [CNT_W-1:0] stat_cnt [NUM_STAT];

  rxlf_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (in_valid),
    .beat_first (in_sof),
    .len_now    (len_now)
  );

  rxlf_classify #(
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN)
  ) u_cls (
    .len       (len_now),
    .crc_ok    (in_crc_ok),
    .short_en  (cfg_short_en),
    .long_en   (cfg_long_en),
    .buf_limit (cfg_buf_limit),
    .keep      (keep),
    .len_cls   (len_cls)
  );

  // next-state logic
  logic       ov_d, os_d, oe_d, disc_d, acc_d, drop_d;
  logic [7:0] od_d;

  always_comb begin
    frame_end = in_valid && in_eof;
    ov_d      = in_valid;
    os_d      = in_valid && in_sof;
    oe_d      = frame_end;
    od_d      = in_valid ? in_data : 8'h00;
    acc_d     = frame_end && keep;
    drop_d    = frame_end && !keep;
    disc_d    = drop_d;
    stat_inc[STAT_ACC]  = acc_d;
    stat_inc[STAT_RUNT] = drop_d && (len_cls == LCLS_RUNT);
    stat_inc[STAT_LONG] = drop_d && (len_cls == LCLS_LONG);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sof     <= 1'b0;
      out_eof     <= 1'b0;
      out_data    <= 8'h00;
      out_discard <= 1'b0;
      acc_pulse   <= 1'b0;
      drop_pulse  <= 1'b0;
    end else begin
      out_valid   <= ov_d;
      out_sof     <= os_d;
      out_eof     <= oe_d;
      out_data    <= od_d;
      out_discard <= disc_d;
      acc_pulse   <= acc_d;
      drop_pulse  <= drop_d;
    end
  end

  for (genvar g = 0; g < NUM_STAT; g++) begin : g_stat
    rxlf_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (stat_inc[g]),
      .count (stat_cnt[g])
    );
  end

  assign cnt_accept    = stat_cnt[STAT_ACC];
  assign cnt_runt_drop = stat_cnt[STAT_RUNT];
  assign cnt_long_drop = stat_cnt[STAT_LONG];
endmodule

// File: rtl/rxlf_checker.sv
module rxlf_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eof,
  input logic             acc_pulse,
  input logic             drop_pulse,
  input logic             out_valid,
  input logic             out_eof,
  input logic             out_discard,
  input logic [CNT_W-1:0] cnt_accept
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_pulse && drop_pulse));

  a_r6_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (acc_pulse || drop_pulse)) |-> $past(in_valid && in_eof));

  a_r6_eof_decides: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof) |=> (acc_pulse || drop_pulse));

  a_r7_discard_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> (out_discard == drop_pulse));

  a_r7_discard_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
    out_discard |-> (out_valid && out_eof));

  a_r8_acc_holds_top: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cnt_accept) == TOP) |-> (cnt_accept == TOP));

  a_r8_acc_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && acc_pulse && $past(cnt_accept) != TOP)
      |-> (cnt_accept == $past(cnt_accept) + CNT_W'(1)));
endmodule

bind rx_len_filter rxlf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_eof      (in_eof),
  .acc_pulse   (acc_pulse),
  .drop_pulse  (drop_pulse),
  .out_valid   (out_valid),
  .out_eof     (out_eof),
  .out_discard (out_discard),
  .cnt_accept  (cnt_accept)
);

// File: tb/rx_len_filter_tb.sv
module rx_len_filter_tb;
  localparam int LEN_W = 14;
  localparam int CNT_W = 16;
  localparam int NV    = 14;

  typedef struct packed {
    logic [15:0] len;
    logic        crc;
    logic        sen;
    logic        len_en;
    logic        gap;
    logic [15:0] limit;
    logic        exp_acc;
  } vec_t;

  // columns: length, crc, short_en, long_en, gaps, limit, expected accept
  localparam vec_t VECS [NV] = '{
    '{16'd64,   1'b1, 1'b0, 1'b0, 1'b0, 16'd2000, 1'b1},  // R1 lower edge
    '{16'd1522, 1'b1, 1'b0, 1'b0, 1'b0, 16'd2000, 1'b1},  // R1 upper edge
    '{16'd100,  1'b0, 1'b0, 1'b0, 1'b0, 16'd2000, 1'b0},  // R1 bad crc
    '{16'd63,   1'b1, 1'b0, 1'b0, 1'b0, 16'd2000, 1'b0},  // R2
    '{16'd20,   1'b1, 1'b0, 1'b1, 1'b0, 16'd2000, 1'b0},  // R2 long_en irrelevant
    '{16'd63,   1'b1, 1'b1, 1'b0, 1'b0, 16'd2000, 1'b1},  // R3
    '{16'd10,   1'b0, 1'b1, 1'b0, 1'b0, 16'd2000, 1'b0},  // R3 bad crc
    '{16'd1,    1'b1, 1'b1, 1'b0, 1'b0, 16'd2000, 1'b1},  // R3 single byte
    '{16'd1523, 1'b1, 1'b1, 1'b0, 1'b0, 16'd2000, 1'b0},  // R4
    '{16'd1523, 1'b1, 1'b0, 1'b1, 1'b0, 16'd2000, 1'b1},  // R5
    '{16'd2000, 1'b1, 1'b0, 1'b1, 1'b0, 16'd2000, 1'b1},  // R5 at limit
    '{16'd2001, 1'b1, 1'b0, 1'b1, 1'b0, 16'd2000, 1'b0},  // R5 one over
    '{16'd1600, 1'b0, 1'b0, 1'b1, 1'b0, 16'd2000, 1'b0},  // R5 bad crc
    '{16'd64,   1'b1, 1'b0, 1'b0, 1'b1, 16'd2000, 1'b1}   // R6 gapped beats
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid, in_sof, in_eof, in_crc_ok;
  logic [7:0]       in_data;
  logic             cfg_short_en, cfg_long_en;
  logic [LEN_W-1:0] cfg_buf_limit;
  logic             out_valid, out_sof, out_eof, out_discard;
  logic [7:0]       out_data;
  logic             acc_pulse, drop_pulse;
  logic [CNT_W-1:0] cnt_accept, cnt_runt_drop, cnt_long_drop;

  always #5 clk = ~clk;

  rx_len_filter u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_sof (in_sof), .in_eof (in_eof),
    .in_data (in_data), .in_crc_ok (in_crc_ok),
    .cfg_short_en (cfg_short_en), .cfg_long_en (cfg_long_en),
    .cfg_buf_limit (cfg_buf_limit),
    .out_valid (out_valid), .out_sof (out_sof), .out_eof (out_eof),
    .out_data (out_data), .out_discard (out_discard),
    .acc_pulse (acc_pulse), .drop_pulse (drop_pulse),
    .cnt_accept (cnt_accept), .cnt_runt_drop (cnt_runt_drop),
    .cnt_long_drop (cnt_long_drop)
  );

  int n_chk = 0;
  int n_bad = 0;
  int exp_acc = 0, exp_runt = 0, exp_long = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic int sat16(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  // Drives one frame; returns at the negedge where the decision is visible.
  task automatic send_frame(input int len, input bit crc, input bit gap, output bit data_ok);
    bit   prev_drove = 1'b0;
    logic [7:0] prev_byte = 8'h00;
    data_ok = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (prev_drove && !(out_valid && out_data == prev_byte)) data_ok = 1'b0;
      in_valid  = 1'b1;
      in_sof    = (i == 0);
      in_eof    = (i == len - 1);
      in_data   = 8'((i * 7 + 3) & 255);
      in_crc_ok = crc;
      prev_byte = in_data;
      prev_drove = 1'b1;
      if (gap && i != len - 1) begin
        @(negedge clk);
        if (!(out_valid && out_data == prev_byte)) data_ok = 1'b0;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'hEE;
        prev_drove = 1'b0;
      end
    end
    @(negedge clk);
    if (!(out_valid && out_eof && out_data == prev_byte)) data_ok = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_crc_ok = 1'b0;
  endtask

  task automatic check_stats(input string req);
    check(cnt_accept == CNT_W'(sat16(exp_acc)), {req, " R8 accept count"}, cnt_accept, sat16(exp_acc));
    check(cnt_runt_drop == CNT_W'(sat16(exp_runt)), {req, " R8 runt count"}, cnt_runt_drop, sat16(exp_runt));
    check(cnt_long_drop == CNT_W'(sat16(exp_long)), {req, " R8 long count"}, cnt_long_drop, sat16(exp_long));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    bit dok;
    rst_n = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00; in_crc_ok = 1'b0;
    cfg_short_en = 1'b0; cfg_long_en = 1'b0; cfg_buf_limit = LEN_W'(2000);
    repeat (3) @(negedge clk);
    // R10 during reset
    check(!acc_pulse && !drop_pulse && !out_valid && !out_discard, "R10 outputs in reset", acc_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cnt_accept == 0 && cnt_runt_drop == 0 && cnt_long_drop == 0, "R10 counters", cnt_accept, 0);
    check(!acc_pulse && !drop_pulse && !out_valid, "R10 pulses after reset", drop_pulse, 0);

    for (int v = 0; v < NV; v++) begin
      int  L;
      bit  ea;
      L  = int'(VECS[v].len);
      ea = VECS[v].exp_acc;
      cfg_short_en  = VECS[v].sen;
      cfg_long_en   = VECS[v].len_en;
      cfg_buf_limit = LEN_W'(VECS[v].limit);
      send_frame(L, VECS[v].crc, VECS[v].gap, dok);
      if (ea) exp_acc++;
      else if (L < 64) exp_runt++;
      else if (L > 1522) exp_long++;
      check(acc_pulse == ea && drop_pulse == !ea, $sformatf("R1-5 decision vec %0d", v), acc_pulse, ea);
      check(out_discard == !ea, $sformatf("R7 discard vec %0d", v), out_discard, !ea);
      check(dok, $sformatf("R7 forwarded data vec %0d", v), dok, 1);
      check_stats($sformatf("vec %0d", v));
      @(negedge clk);
      check(!acc_pulse && !drop_pulse, $sformatf("R6 single pulse vec %0d", v), acc_pulse | drop_pulse, 0);
    end

    // R9: frame longer than the byte counter range must stay oversize
    cfg_short_en = 1'b1; cfg_long_en = 1'b0;
    send_frame(16400, 1'b1, 1'b0, dok);
    exp_long++;
    check(drop_pulse && !acc_pulse, "R9 saturated length dropped", drop_pulse, 1);
    check(cnt_long_drop == CNT_W'(exp_long), "R9 counted as oversize", cnt_long_drop, exp_long);

    // R8: accept counter saturation with back-to-back one-byte frames
    cfg_short_en = 1'b1;
    for (int k = 0; k < 65540; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_crc_ok = 1'b1; in_data = 8'(k);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    exp_acc += 65540;
    check(acc_pulse, "R8 last burst frame accepted", acc_pulse, 1);
    @(negedge clk);
    check(cnt_accept == 16'hFFFF, "R8 accept saturates", cnt_accept, 65535);
    check_stats("R8 after burst");

    summary();
  end
endmodule